// File: doc/BRIEF.md
# Multi-Block DMA Sequencer

This block decides what one DMA channel does between two consecutive blocks. While the channel is running, an external datapath moves the data of a block and pulses `blk_done` when the block ends. It also presents the addresses that would follow the last transfer on each side. The sequencer then chooses the source and destination start addresses for the next block. Each side has its own policy: it can reload the value software first programmed, continue from where the previous block ended, or take the address from a descriptor in memory.

Descriptors are read one word at a time through a simple request/acknowledge read port. A descriptor carries new control words and a pointer to the next descriptor. A zero pointer closes the chain. When neither side reloads and neither side is linked, the channel performs one block and stops. A channel that reloads keeps running until software asks it to stop. It then ends at the next block boundary.

Five per-channel events land in a raw register. The events are block end, transfer end, source transaction, destination transaction and error. A mask register gates the raw bits into a status vector, and any set status bit drives `irq`. Software clears raw bits by writing ones to a clear register.

Top module: `dma_blkseq`

## Requirements
- R1: On a side whose policy is reload (policy code 1), every block after the first starts at the address programmed for that side. Both control words are also restored to their programmed values when no side is linked.
- R2: On a side whose policy is contiguous (policy code 0, code 3 acts the same), the next block starts at the address the datapath presents on `nxt_src`/`nxt_dst` with `blk_done`. The two sides follow their own policies independently. Policy field: bits [1:0] of register 5 for the source, bits [3:2] for the destination.
- R3: With both sides contiguous, the channel runs exactly one block. `ch_active` then falls and no further `blk_go` appears.
- R4: On a side whose policy is linked (code 2), the block end starts a fetch of five words at pointer+0, +4, +8, +12, +16, in this order: source address, destination address, next pointer, control low, control high. The address words are applied only to linked sides. The pointer and control words are always applied.
- R5: A channel with a linked side ends its transfer at the first block end where the current next pointer is zero.
- R6: `blk_go` for the next block does not assert before the fifth descriptor word has been acknowledged. One word is taken per cycle in which `rd_req` and `rd_ack` are both high.
- R7: Every block end sets raw bit 0 (block complete). Raw bit 1 (transfer complete) is set only at the block end that stops the channel. For a channel that reloads, this is the first block end at or after a `stop` pulse.
- R8: `stat_evt` equals raw AND mask (register 6), and `irq` is high exactly when `stat_evt` is non-zero.
- R9: A write of ones to register 7 clears those raw bits. When an event sets a bit in the same cycle that bit is cleared, the clear wins and the bit is set one cycle later.
- R10: Pulses on `src_txn`, `dst_txn` and `err_evt` set raw bits 2, 3 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_we | input | 1 | Register write strobe |
| prog_addr | input | 3 | 0 src, 1 dst, 2 ctl low, 3 ctl high, 4 next pointer, 5 policy, 6 mask, 7 clear |
| prog_wdata | input | AW | Register write data |
| start | input | 1 | Enable the channel when idle |
| stop | input | 1 | Request the channel to end at the next block end |
| blk_done | input | 1 | Datapath reports the current block finished |
| nxt_src | input | AW | Source address following the finished block |
| nxt_dst | input | AW | Destination address following the finished block |
| src_txn | input | 1 | Source transaction event |
| dst_txn | input | 1 | Destination transaction event |
| err_evt | input | 1 | Error event |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | AW | Descriptor word address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | AW | Descriptor word |
| blk_go | output | 1 | One-cycle pulse: current registers are valid, start a block |
| ch_active | output | 1 | Channel enabled |
| cur_src | output | AW | Source address of the current block |
| cur_dst | output | AW | Destination address of the current block |
| cur_ctl_lo | output | AW | Current control low word |
| cur_ctl_hi | output | AW | Current control high word |
| cur_llp | output | AW | Current next-descriptor pointer |
| raw_evt | output | 5 | Raw event bits |
| stat_evt | output | 5 | Masked event bits |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong policy decision at a block end shows up at the next `blk_go`, one cycle later or six cycles later after a fetch. The start addresses then differ from the expected reload, continuation or descriptor value, or the channel drops `ch_active` early or never. A corrupted event register appears at the ports the cycle after the faulty edge, because the bench compares `raw_evt` and `stat_evt` with its own event model on every clock. A misordered or miscounted fetch shows in the logged read addresses and in the fields loaded for the following block.

// File: rtl/dma_blkseq.sv
module dma_blkseq #(
  parameter int AW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [2:0]    prog_addr,
  input  logic [AW-1:0] prog_wdata,
  input  logic          start,
  input  logic          stop,
  input  logic          blk_done,
  input  logic [AW-1:0] nxt_src,
  input  logic [AW-1:0] nxt_dst,
  input  logic          src_txn,
  input  logic          dst_txn,
  input  logic          err_evt,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [AW-1:0] rd_data,
  output logic          blk_go,
  output logic          ch_active,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [AW-1:0] cur_ctl_lo,
  output logic [AW-1:0] cur_ctl_hi,
  output logic [AW-1:0] cur_llp,
  output logic [4:0]    raw_evt,
  output logic [4:0]    stat_evt,
  output logic          irq
);
  localparam int NEV = 5;
  localparam int NWORDS = 5;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  localparam logic [2:0] LAST_IDX = 3'(NWORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_GO, S_RUN, S_FETCH} st_t;
  st_t state;

  logic [AW-1:0] init_src, init_dst, init_clo, init_chi, init_llp, fptr;
  logic [3:0]    pol;
  logic [NEV-1:0] mask, raw, held;
  logic [2:0]    fidx;
  logic          stop_pend;

  wire src_rl = pol[1:0] == 2'd1;
  wire src_ll = pol[1:0] == 2'd2;
  wire dst_rl = pol[3:2] == 2'd1;
  wire dst_ll = pol[3:2] == 2'd2;
  wire any_rl = src_rl | dst_rl;
  wire any_ll = src_ll | dst_ll;

  wire blk_end = (state == S_RUN) && blk_done;
  wire finish  = blk_end && (stop_pend || stop || (any_ll ? (cur_llp == '0) : !any_rl));

  wire [NEV-1:0] ev   = {err_evt, dst_txn, src_txn, finish, blk_end};
  wire [NEV-1:0] clr  = (prog_we && prog_addr == 3'd7) ? prog_wdata[NEV-1:0] : '0;
  wire [NEV-1:0] setv = ev | held;

  assign rd_req    = state == S_FETCH;
  assign rd_addr   = fptr + AW'(fidx) * STEP;
  assign blk_go    = state == S_GO;
  assign ch_active = state != S_IDLE;
  assign raw_evt   = raw;
  assign stat_evt  = raw & mask;
  assign irq       = |stat_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      init_src <= '0; init_dst <= '0; init_clo <= '0; init_chi <= '0; init_llp <= '0;
      cur_src <= '0; cur_dst <= '0; cur_ctl_lo <= '0; cur_ctl_hi <= '0; cur_llp <= '0;
      fptr <= '0; fidx <= '0; pol <= '0; mask <= '0; raw <= '0; held <= '0;
      stop_pend <= 1'b0;
    end else begin
      if (prog_we) begin
        case (prog_addr)
          3'd0: init_src <= prog_wdata;
          3'd1: init_dst <= prog_wdata;
          3'd2: init_clo <= prog_wdata;
          3'd3: init_chi <= prog_wdata;
          3'd4: init_llp <= prog_wdata;
          3'd5: pol <= prog_wdata[3:0];
          3'd6: mask <= prog_wdata[NEV-1:0];
          default: ;
        endcase
      end
      raw  <= (raw | setv) & ~clr;
      held <= setv & clr;
      if (state != S_IDLE && stop) stop_pend <= 1'b1;
      case (state)
        S_IDLE: if (start) begin
          cur_src <= init_src; cur_dst <= init_dst;
          cur_ctl_lo <= init_clo; cur_ctl_hi <= init_chi; cur_llp <= init_llp;
          stop_pend <= 1'b0;
          state <= S_GO;
        end
        S_GO: state <= S_RUN;
        S_RUN: if (blk_done) begin
          if (finish) begin
            stop_pend <= 1'b0;
            state <= S_IDLE;
          end else begin
            cur_src <= src_rl ? init_src : nxt_src;
            cur_dst <= dst_rl ? init_dst : nxt_dst;
            if (any_ll) begin
              fptr  <= cur_llp;
              fidx  <= '0;
              state <= S_FETCH;
            end else begin
              if (any_rl) begin
                cur_ctl_lo <= init_clo;
                cur_ctl_hi <= init_chi;
              end
              state <= S_GO;
            end
          end
        end
        S_FETCH: if (rd_ack) begin
          case (fidx)
            3'd0: if (src_ll) cur_src <= rd_data;
            3'd1: if (dst_ll) cur_dst <= rd_data;
            3'd2: cur_llp <= rd_data;
            3'd3: cur_ctl_lo <= rd_data;
            default: cur_ctl_hi <= rd_data;
          endcase
          fidx <= fidx + 3'd1;
          if (fidx == LAST_IDX) state <= S_GO;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RELOAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && !finish && src_rl && !(prog_we && prog_addr == 3'd0)) |=> (cur_src == init_src)); // R1
  AST_SINGLE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && pol == 4'd0) |=> !ch_active); // R3
  AST_LAST_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && any_ll && cur_llp == '0) |=> (state == S_IDLE)); // R5
  AST_FETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !(rd_ack && fidx == LAST_IDX)) |=> !blk_go); // R6
  AST_BLK_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> (raw[0] | held[0])); // R7
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((raw & $past(clr)) == '0)); // R9
endmodule

// File: tb/sim_dma_blkseq.sv
`timescale 1ns/1ps
module sim_dma_blkseq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [2:0] prog_addr = '0;
  logic [31:0] prog_wdata = '0;
  logic start = 1'b0, stop = 1'b0, blk_done = 1'b0;
  logic [31:0] nxt_src = '0, nxt_dst = '0;
  logic src_txn = 1'b0, dst_txn = 1'b0, err_evt = 1'b0;
  logic rd_req, rd_ack = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic blk_go, ch_active, irq;
  logic [31:0] cur_src, cur_dst, cur_ctl_lo, cur_ctl_hi, cur_llp;
  logic [4:0] raw_evt, stat_evt;
  logic exp_xfer = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] mem [0:127];
  logic [31:0] rd_log [$];

  always #2.5 clk = ~clk;

  dma_blkseq u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // behavioural event model
  logic [4:0] m_raw = '0, m_held = '0, m_mask = '0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw <= '0; m_held <= '0; m_mask <= '0;
    end else begin
      logic [4:0] e, c;
      e = {err_evt, dst_txn, src_txn, exp_xfer & blk_done, blk_done} | m_held;
      c = (prog_we && prog_addr == 3'd7) ? prog_wdata[4:0] : 5'd0;
      m_raw  <= (m_raw | e) & ~c;
      m_held <= e & c;
      if (prog_we && prog_addr == 3'd6) m_mask <= prog_wdata[4:0];
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R7", {27'd0, raw_evt}, {27'd0, m_raw}, "raw events vs model");
    chk("R8", {27'd0, stat_evt}, {27'd0, m_raw & m_mask}, "status vs model");
    chk("R8", {31'd0, irq}, {31'd0, |(m_raw & m_mask)}, "irq vs model");
    if (rd_req && blk_go) chk("R6", 32'd1, 32'd0, "blk_go during fetch");
  end

  // descriptor memory responder, one word per cycle
  always @(negedge clk) begin
    rd_ack  = rd_req;
    rd_data = mem[rd_addr[8:2]];
  end
  always @(posedge clk) if (rst_n && rd_req && rd_ack) rd_log.push_back(rd_addr);

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    prog_we = 1'b1; prog_addr = a; prog_wdata = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic go_channel();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_go();
    while (!blk_go) @(negedge clk);
  endtask

  task automatic end_block(input logic [31:0] s, input logic [31:0] d, input logic last);
    @(negedge clk);
    blk_done = 1'b1; nxt_src = s; nxt_dst = d; exp_xfer = last;
    @(negedge clk);
    blk_done = 1'b0; exp_xfer = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[64] = 32'hA000; mem[65] = 32'hB000; mem[66] = 32'h140; mem[67] = 32'h11; mem[68] = 32'h22;
    mem[80] = 32'hA800; mem[81] = 32'hB800; mem[82] = 32'h0;   mem[83] = 32'h33; mem[84] = 32'h44;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", {27'd0, raw_evt, irq, ch_active, rd_req}, 32'd0, "reset state");

    // R3 single block
    wr(0, 32'h1000); wr(1, 32'h2000); wr(5, 32'h0); wr(6, 32'h1f);
    go_channel(); wait_go();
    chk("R3", cur_src, 32'h1000, "first block source");
    end_block(32'h1010, 32'h2010, 1'b1);
    chk("R3", {31'd0, ch_active}, 32'd0, "single block stops");
    repeat (3) @(negedge clk);
    chk("R3", {31'd0, blk_go}, 32'd0, "no second block");
    chk("R7", {27'd0, raw_evt}, 32'h3, "block and transfer complete");
    wr(7, 32'h1f);

    // R1/R2 source reload, destination contiguous, then stop
    wr(0, 32'h3000); wr(1, 32'h4000); wr(2, 32'h55); wr(3, 32'h66); wr(5, 32'h1);
    go_channel(); wait_go();
    wr(2, 32'h77);
    end_block(32'h3020, 32'h4020, 1'b0);
    wait_go();
    chk("R1", cur_src, 32'h3000, "reload source");
    chk("R2", cur_dst, 32'h4020, "contiguous destination");
    chk("R1", cur_ctl_lo, 32'h77, "control restored");
    chk("R7", {27'd0, raw_evt}, 32'h1, "block complete only");
    end_block(32'h3020, 32'h4040, 1'b0);
    wait_go();
    chk("R2", cur_dst, 32'h4040, "second continuation");
    chk("R7", {31'd0, ch_active}, 32'd1, "reload keeps running");
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    chk("R7", {31'd0, raw_evt[1]}, 32'd0, "no transfer end before block end");
    end_block(32'h3020, 32'h4060, 1'b1);
    chk("R7", {31'd0, ch_active}, 32'd0, "stop ends at block end");
    chk("R7", {30'd0, raw_evt[1:0]}, 32'h3, "transfer complete on stop");
    wr(7, 32'h1f);

    // R4/R5/R6 both sides linked
    rd_log.delete();
    wr(0, 32'h1000); wr(1, 32'h2000); wr(4, 32'h100); wr(5, 32'ha);
    go_channel(); wait_go();
    end_block(32'h1040, 32'h2040, 1'b0);
    chk("R6", {31'd0, blk_go}, 32'd0, "no block start while fetching");
    wait_go();
    chk("R6", rd_log.size(), 32'd5, "five words fetched");
    for (int i = 0; i < 5 && i < rd_log.size(); i++)
      chk("R4", rd_log[i], 32'h100 + 32'(4 * i), "fetch address order");
    chk("R4", cur_src, 32'hA000, "descriptor source");
    chk("R4", cur_dst, 32'hB000, "descriptor destination");
    chk("R4", cur_llp, 32'h140, "descriptor pointer");
    chk("R4", {cur_ctl_hi[15:0], cur_ctl_lo[15:0]}, 32'h00220011, "descriptor control");
    end_block(32'h0, 32'h0, 1'b0);
    wait_go();
    chk("R4", cur_src, 32'hA800, "second descriptor source");
    chk("R5", cur_llp, 32'h0, "zero pointer loaded");
    end_block(32'h0, 32'h0, 1'b1);
    chk("R5", {31'd0, ch_active}, 32'd0, "chain ends at zero pointer");
    wr(7, 32'h1f);

    // R2/R4 source linked, destination contiguous
    wr(1, 32'h2000); wr(5, 32'h2);
    go_channel(); wait_go();
    end_block(32'h1040, 32'h2040, 1'b0);
    wait_go();
    chk("R4", cur_src, 32'hA000, "linked source side");
    chk("R2", cur_dst, 32'h2040, "contiguous side independent");
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    end_block(32'h0, 32'h0, 1'b1);
    wr(7, 32'h1f);

    // R9 clear collides with block complete
    wr(5, 32'h0);
    go_channel(); wait_go();
    @(negedge clk);
    blk_done = 1'b1; exp_xfer = 1'b1; prog_we = 1'b1; prog_addr = 3'd7; prog_wdata = 32'h1;
    @(negedge clk);
    blk_done = 1'b0; exp_xfer = 1'b0; prog_we = 1'b0;
    chk("R9", {27'd0, raw_evt}, 32'h2, "clear wins same cycle");
    @(negedge clk);
    chk("R9", {27'd0, raw_evt}, 32'h3, "held set lands next cycle");
    wr(7, 32'h1f);
    @(negedge clk);
    chk("R9", {27'd0, raw_evt}, 32'h0, "clear all");

    // R10 transaction and error events, R8 mask
    wr(6, 32'h0);
    src_txn = 1'b1; err_evt = 1'b1; @(negedge clk); src_txn = 1'b0; err_evt = 1'b0;
    dst_txn = 1'b1; @(negedge clk); dst_txn = 1'b0;
    chk("R10", {27'd0, raw_evt}, 32'h1c, "transaction and error bits");
    chk("R8", {31'd0, irq}, 32'd0, "fully masked");
    wr(6, 32'h4);
    chk("R8", {27'd0, stat_evt}, 32'h4, "masked status");
    chk("R8", {31'd0, irq}, 32'd1, "irq from unmasked bit");
    wr(7, 32'h4);
    chk("R8", {31'd0, irq}, 32'd0, "irq drops after clear");
    repeat (3) @(negedge clk);
    report();
  end
endmodule